// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces what a host sees when it reads a flash device while the internal program/erase engine is at work. It takes the engine's state (program running, erase running, erase suspended), a mask of sectors chosen for erasure and a mask of protected sectors. It also takes read strobes with their address. On each read it chooses between returning toggle status and passing array data through.

Two status bits carry the information. Bit 6 inverts on every status read while any embedded algorithm is running, so it shows device-wide activity. Bit 2 inverts only on reads that land in a sector chosen for erasure, so it shows which sectors are involved. A program aimed at a protected sector, or an erase whose chosen sectors are all protected, does not start the engine. In that case the block itself opens a short timed window of toggling and then falls back to array reads. The ready/busy pin is modelled as an active-low open-drain enable, so several devices can share one wire.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, dout is all zeros and ryby_od_n is 1 (released). Both toggle states start at 0, so the first status read returns 0 on bit 6 and on a toggling bit 2.
- R2: While busy_pgm, busy_erase or the protection window is active, every read at any address is a status read. Each such read returns the current bit 6 state, and the state then inverts.
- R3: When no algorithm is running and no window is open, bit 6 does not change. Successive suspend-mode status reads return the same bit 6.
- R4: On a status read whose address sector (rd_addr[ADDR_W-1 -: log2(NUM_SECT)]) is set in sel_mask while busy_erase or erase_susp is 1, bit 2 returns its state and then inverts. On every other status read, bit 2 is 1.
- R5: A read with no algorithm running and no window open returns array_data unchanged. This also holds in suspend for a sector that is not chosen for erasure.
- R6: On a status read, every dout bit other than 6 and 2 equals array_data.
- R7: A cmd_pgm_start pulse whose cmd_addr sector is set in prot_mask opens a window of CLK_MHZ*PROT_WIN_NS/1000 cycles. During the window, reads toggle bit 6. After it closes, reads return array data. A program to an unprotected sector opens no window.
- R8: A cmd_erase_start pulse opens the same window when sel_mask is non-zero and every chosen sector is protected. If any chosen sector is unprotected, no window opens.
- R9: ryby_od_n is 0 in the cycle after busy_pgm, busy_erase or the window is active, and 1 otherwise. This includes erase-suspend without a program running.
- R10: dout holds its value in cycles without rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_pgm | input | 1 | Program algorithm running (including inside suspend) |
| busy_erase | input | 1 | Erase algorithm running (including sector time-out) |
| erase_susp | input | 1 | Erase is suspended |
| cmd_pgm_start | input | 1 | Pulse on the final write strobe of a program command |
| cmd_erase_start | input | 1 | Pulse on the final write strobe of an erase command |
| cmd_addr | input | ADDR_W | Address of the program command |
| sel_mask | input | NUM_SECT | Sectors chosen for erasure |
| prot_mask | input | NUM_SECT | Protected sectors |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Array contents at rd_addr |
| dout | output | DATA_W | Read data, registered |
| ryby_od_n | output | 1 | 0 pulls the shared ready/busy wire low |

## Verification
A stuck or wrongly reset toggle register shows up on the first or second status read. Two consecutive reads show equal bit 6 where they should differ, or the reverse in suspend. A wrong sector decode shows up the first time bit 2 toggles on a read outside the chosen sectors. A wrong window counter shows up as toggling reads at the window edge, or as ryby_od_n still low once the window is over. Such a counter error therefore appears within one window length plus one cycle.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY       = 2'd0,
    RD_STATUS_RUN  = 2'd1,
    RD_STATUS_SUSP = 2'd2
  } rd_kind_e;

  localparam int unsigned TOG_RUN_BIT = 6;
  localparam int unsigned TOG_SEL_BIT = 2;
endpackage

// File: rtl/flash_sector_decode.sv
module flash_sector_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_SECT = 8
) (
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [NUM_SECT-1:0] sel_mask,
  input  logic [NUM_SECT-1:0] prot_mask,
  output logic                rd_in_sel,
  output logic                cmd_in_prot,
  output logic                sel_all_prot
);
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic [SECT_W-1:0] rd_sect;
  logic [SECT_W-1:0] cmd_sect;

  always_comb begin
    rd_sect      = rd_addr[ADDR_W-1 -: SECT_W];
    cmd_sect     = cmd_addr[ADDR_W-1 -: SECT_W];
    rd_in_sel    = sel_mask[rd_sect];
    cmd_in_prot  = prot_mask[cmd_sect];
    sel_all_prot = (sel_mask != '0) && ((sel_mask & ~prot_mask) == '0);
  end
endmodule

// File: rtl/flash_prot_window.sv
module flash_prot_window #(
  parameter int unsigned WIN_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = CNT_W'(WIN_CYC);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R7
  win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_W'(WIN_CYC)));
endmodule

// File: rtl/flash_toggle_core.sv
module flash_toggle_core
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              run_act,
  input  logic              erase_ctx,
  input  logic              susp,
  input  logic              rd_in_sel,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout
);
  rd_kind_e          kind;
  logic              tog_run_q, tog_run_d;
  logic              tog_sel_q, tog_sel_d;
  logic              sel_live;
  logic [DATA_W-1:0] dout_q, dout_d;

  always_comb begin
    if (run_act)                kind = RD_STATUS_RUN;
    else if (susp && rd_in_sel) kind = RD_STATUS_SUSP;
    else                        kind = RD_ARRAY;

    sel_live  = (kind != RD_ARRAY) && rd_in_sel && erase_ctx;
    tog_run_d = tog_run_q;
    tog_sel_d = tog_sel_q;
    dout_d    = dout_q;

    if (rd_stb) begin
      dout_d = array_data;
      if (kind != RD_ARRAY) begin
        dout_d[TOG_RUN_BIT] = tog_run_q;
        dout_d[TOG_SEL_BIT] = sel_live ? tog_sel_q : 1'b1;
      end
      if (kind == RD_STATUS_RUN) tog_run_d = ~tog_run_q;
      if (sel_live)              tog_sel_d = ~tog_sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_run_q <= 1'b0;
      tog_sel_q <= 1'b0;
      dout_q    <= '0;
    end else if (rd_stb) begin
      tog_run_q <= tog_run_d;
      tog_sel_q <= tog_sel_d;
      dout_q    <= dout_d;
    end
  end

  assign dout = dout_q;

  // R2
  run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && run_act) |=> (tog_run_q != $past(tog_run_q)));

  // R3
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_act |=> $stable(tog_run_q));

  // R4
  sel_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_in_sel && erase_ctx && (run_act || susp)) |=> (tog_sel_q != $past(tog_sel_q)));

  // R5
  array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !run_act && !(susp && rd_in_sel)) |=> (dout == $past(array_data)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dout));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned PROT_WIN_NS = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_pgm,
  input  logic                busy_erase,
  input  logic                erase_susp,
  input  logic                cmd_pgm_start,
  input  logic                cmd_erase_start,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [NUM_SECT-1:0] sel_mask,
  input  logic [NUM_SECT-1:0] prot_mask,
  input  logic                rd_stb,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   array_data,
  output logic [DATA_W-1:0]   dout,
  output logic                ryby_od_n
);
  localparam int unsigned WIN_CYC = (CLK_MHZ * PROT_WIN_NS) / 1000;

  logic rd_in_sel, cmd_in_prot, sel_all_prot;
  logic win_start, win_act, run_act, erase_ctx;
  logic ryby_q, ryby_d;

  flash_sector_decode #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_dec (
    .rd_addr     (rd_addr),
    .cmd_addr    (cmd_addr),
    .sel_mask    (sel_mask),
    .prot_mask   (prot_mask),
    .rd_in_sel   (rd_in_sel),
    .cmd_in_prot (cmd_in_prot),
    .sel_all_prot(sel_all_prot)
  );

  always_comb begin
    win_start = (cmd_pgm_start && cmd_in_prot) || (cmd_erase_start && sel_all_prot);
    run_act   = busy_pgm || busy_erase || win_act;
    erase_ctx = busy_erase || erase_susp;
    ryby_d    = !run_act;
  end

  flash_prot_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (win_start),
    .active(win_act)
  );

  flash_toggle_core #(.DATA_W(DATA_W)) u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .run_act   (run_act),
    .erase_ctx (erase_ctx),
    .susp      (erase_susp),
    .rd_in_sel (rd_in_sel),
    .array_data(array_data),
    .dout      (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ryby_q <= 1'b1;
    else        ryby_q <= ryby_d;
  end

  assign ryby_od_n = ryby_q;

  // R9
  ryby_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ryby_od_n == !($past(busy_pgm) || $past(busy_erase) || $past(win_act))));

  // R9
  susp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && !busy_pgm && !busy_erase && !win_act) |=> ryby_od_n);
endmodule

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
  localparam int AW = 12;
  localparam int NS = 8;
  localparam int DW = 8;
  localparam int WIN = 500;

  logic clk = 1'b0;
  logic rst_n;
  logic busy_pgm, busy_erase, erase_susp, cmd_pgm_start, cmd_erase_start, rd_stb;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [NS-1:0] sel_mask, prot_mask;
  logic [DW-1:0] array_data, dout;
  logic ryby_od_n;

  int checks = 0;
  int failures = 0;
  bit m_dq6, m_dq2;
  int m_win;
  logic [DW-1:0] m_dout;

  always #2 clk = ~clk;

  flash_status_gen uut (
    .clk(clk), .rst_n(rst_n), .busy_pgm(busy_pgm), .busy_erase(busy_erase),
    .erase_susp(erase_susp), .cmd_pgm_start(cmd_pgm_start), .cmd_erase_start(cmd_erase_start),
    .cmd_addr(cmd_addr), .sel_mask(sel_mask), .prot_mask(prot_mask), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .array_data(array_data), .dout(dout), .ryby_od_n(ryby_od_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] sect_of(input logic [AW-1:0] a);
    return a[AW-1 -: 3];
  endfunction

  task automatic cycle(input string tag);
    bit run, sel, live, stat;
    logic [DW-1:0] v;
    string t;
    sel  = sel_mask[sect_of(rd_addr)];
    run  = busy_pgm || busy_erase || (m_win != 0);
    stat = run || (erase_susp && sel);
    t    = tag;
    if (rd_stb) begin
      v = array_data;
      if (stat) begin
        live = sel && (busy_erase || erase_susp);
        v[6] = m_dq6;
        v[2] = live ? m_dq2 : 1'b1;
        if (run)  m_dq6 = ~m_dq6;
        if (live) m_dq2 = ~m_dq2;
        if (t == "") t = run ? "R2" : "R4";
      end else if (t == "") t = "R5";
      m_dout = v;
    end else if (t == "") t = "R10";
    if ((cmd_pgm_start && prot_mask[sect_of(cmd_addr)]) ||
        (cmd_erase_start && sel_mask != 0 && (sel_mask & ~prot_mask) == 0))
      m_win = WIN;
    else if (m_win > 0) m_win--;
    @(posedge clk);
    @(negedge clk);
    check(t, dout, m_dout);
    check("R9", ryby_od_n, !run);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    rd_stb = 1'b1; rd_addr = a; array_data = d;
    cycle(tag);
    rd_stb = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] first6;
    void'($urandom(32'd1234));
    rst_n = 1'b0; busy_pgm = 0; busy_erase = 0; erase_susp = 0;
    cmd_pgm_start = 0; cmd_erase_start = 0; cmd_addr = '0; sel_mask = '0; prot_mask = '0;
    rd_stb = 0; rd_addr = '0; array_data = '0;
    m_dq6 = 0; m_dq2 = 0; m_win = 0; m_dout = '0;
    repeat (3) @(negedge clk);
    check("R1", dout, 0);
    check("R1", ryby_od_n, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 / R6: active erase of sector 2, alternate sectors
    busy_erase = 1; sel_mask = 8'b0000_0100;
    cycle("R9");
    rd({3'd2, 9'h011}, 8'h00, "R1");
    check("R1", dout[6], 0);
    rd({3'd5, 9'h022}, 8'hBB, "R2");
    check("R6", dout & 8'hBB, 8'hBB & ~8'h40 | (dout & 8'h00));
    check("R6", dout & ~8'h44, 8'hBB & ~8'h44);
    check("R4", dout[2], 1);
    rd({3'd2, 9'h033}, 8'h5A, "R4");
    rd({3'd2, 9'h034}, 8'hA5, "R4");

    // R3: suspend reads of chosen sector keep bit 6
    busy_erase = 0; erase_susp = 1;
    rd({3'd2, 9'h001}, 8'h00, "R3");
    first6 = dout;
    rd({3'd2, 9'h002}, 8'h00, "R3");
    check("R3", dout[6], first6[6]);
    rd({3'd6, 9'h003}, 8'h3C, "R5");
    check("R5", dout, 8'h3C);

    // suspend-program: busy again, toggles at every address
    busy_pgm = 1;
    cycle("R9");
    check("R9", ryby_od_n, 0);
    rd({3'd6, 9'h004}, 8'h00, "R2");
    busy_pgm = 0;
    cycle("R9");
    check("R9", ryby_od_n, 1);
    erase_susp = 0; sel_mask = '0;
    rd({3'd1, 9'h005}, 8'hC3, "R5");
    repeat (3) cycle("R10");

    // R7: program to protected sector opens window
    prot_mask = 8'b1000_0001;
    cmd_addr = {3'd7, 9'h0}; cmd_pgm_start = 1;
    cycle("R7"); cmd_pgm_start = 0;
    rd({3'd3, 9'h010}, 8'h11, "R7");
    rd({3'd3, 9'h011}, 8'h11, "R7");
    check("R7", ryby_od_n, 0);
    repeat (WIN) cycle("R7");
    rd({3'd3, 9'h012}, 8'h77, "R7");
    check("R7", dout, 8'h77);
    check("R7", ryby_od_n, 1);
    cmd_addr = {3'd4, 9'h0}; cmd_pgm_start = 1;
    cycle("R7"); cmd_pgm_start = 0;
    rd({3'd4, 9'h001}, 8'h66, "R7");
    check("R7", dout, 8'h66);

    // R8: erase of all-protected selection opens window, partial does not
    sel_mask = 8'b1000_0010; prot_mask = 8'b1000_0011; cmd_erase_start = 1;
    cycle("R8"); cmd_erase_start = 0; sel_mask = '0;
    rd({3'd5, 9'h0}, 8'h00, "R8");
    check("R8", ryby_od_n, 0);
    repeat (WIN + 2) cycle("R8");
    sel_mask = 8'b0000_0110; cmd_erase_start = 1;
    cycle("R8"); cmd_erase_start = 0; sel_mask = '0;
    rd({3'd5, 9'h0}, 8'h99, "R8");
    check("R8", dout, 8'h99);

    // random phase, no command pulses
    for (int i = 0; i < 4000; i++) begin
      int mode;
      mode = $urandom_range(0, 4);
      busy_pgm   = (mode == 1) || (mode == 4);
      busy_erase = (mode == 2);
      erase_susp = (mode == 3) || (mode == 4);
      sel_mask   = NS'($urandom);
      prot_mask  = NS'($urandom);
      rd_stb     = $urandom_range(0, 2) != 0;
      rd_addr    = AW'($urandom);
      array_data = DW'($urandom);
      cycle("");
    end
    rd_stb = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule